// File: doc/BRIEF.md
# Programmable Memory Traffic Generator

The block drives synthetic read and write requests onto a valid/ready request channel and accepts completions on a separate response strobe. Its behaviour comes from a small table of phases held on configuration inputs. A phase either issues a fixed number of requests or waits for a fixed number of clocks. A request phase draws each access type from a programmed read probability. It draws each address either by stepping through a window or at random inside that window. When a phase finishes, the block picks its successor by comparing a random draw against per-edge thresholds. A phase with no outgoing edge stops the run and raises `done`.

All randomness comes from one seeded 32-bit LFSR, so the same seed and table always reproduce the same request stream. The block counts reads and writes in flight separately. While either count sits at its programmed cap, no request is offered. A `start` pulse begins a run from phase 0. The block is meant as a stimulus source in front of a memory subsystem, where a run mixes streaming, scattered and quiet periods.

Top module: `traffic_gen`

## Requirements
- R1: After reset, `req_valid` and `done` are low and both in-flight counts are zero.
- R2: `start` in the stopped or finished condition loads `seed` into the LFSR (a zero seed is replaced by 1) and enters phase 0. Two runs with the same seed and table produce identical request streams.
- R3: The LFSR is a 32-bit Galois register. Each step shifts right and XORs in 0x80200003 when the bit shifted out was 1. It steps once per draw: on entering a phase, on each accepted request that is not the phase's last, and on each successor choice. A request is a read (`req_write`=0) when bits 15:0 of the draw are below the phase's read threshold; otherwise it is a write.
- R4: In stepping mode, the first address of a phase is its lower bound. Each later address is the previous one plus the step. If that sum exceeds the upper bound, the address returns to the lower bound.
- R5: In random mode, the address is lower bound + ((draw bits 31:16) mod (upper − lower + 1)), with that offset rounded down to a multiple of 2^a. Here a is the phase's alignment code, and code 0 selects LEN_LOG2 (the request length).
- R6: A request phase issues exactly its programmed count of requests. A count of 0 issues none.
- R7: A wait phase of N clocks adds N+2 cycles between the last request before it and the next request after it. With `req_ready` held high and no cap reached, the spacing is 1 cycle within a phase and 3 cycles across a direct phase change.
- R8: The successor is the lowest-numbered enabled edge whose threshold is above draw bits 15:0. If no enabled edge qualifies, the highest-numbered enabled edge is taken.
- R9: A phase with no enabled edge ends the run. `done` rises and stays high until the next `start`, and no request is offered meanwhile.
- R10: The read (write) count rises on an accepted read (write) and falls on a response with `rsp_write`=0 (1). Both in one cycle leave it unchanged.
- R11: While the read count is at or above a nonzero `lim_rd`, or the write count is at or above a nonzero `lim_wr`, `req_valid` stays low. A cap of 0 disables that check.
- R12: While `req_valid` is high and `req_ready` low, the request stays offered with unchanged address and type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run at phase 0 |
| seed | input | 32 | LFSR start value |
| cfg_idle | input | NS | Per phase: 1 = wait phase |
| cfg_rand | input | NS | Per phase: 1 = random addresses, 0 = stepping |
| cfg_count | input | NS*CW | Per phase: request count, or wait clocks |
| cfg_rdthr | input | NS*16 | Per phase: read threshold |
| cfg_lo | input | NS*AW | Per phase: lower address bound |
| cfg_hi | input | NS*AW | Per phase: upper address bound |
| cfg_step | input | NS*AW | Per phase: stepping increment |
| cfg_aln | input | NS*4 | Per phase: log2 alignment, 0 = request length |
| cfg_trv | input | NS*NS | Edge enables, bit s*NS+j = phase s to phase j |
| cfg_trthr | input | NS*NS*16 | Edge thresholds, same indexing |
| lim_rd | input | OW | Read in-flight cap, 0 = none |
| lim_wr | input | OW | Write in-flight cap, 0 = none |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request taken |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Request address |
| rsp_valid | input | 1 | One request completed |
| rsp_write | input | 1 | Type of the completed request |
| done | output | 1 | Run finished |

## Verification
A fixed directed table combines a stepping phase that wraps, a wait phase and a random phase. It is run with the ready line held high, so that the exact address order, the window wrap, the alignment and the cycle spacing around the wait can be told apart. The same table is rerun to show that the seed reproduces the stream. A branch table with one never-taken edge separates the threshold rule from the fallback. A write-only phase with withheld responses shows the cap holding requests back and a single response releasing one slot. Many random tables with forward-only edges, random ready, random response timing and small caps then exercise phase mixes, stalls and held requests against a bench model of the LFSR and phase walk.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_ENTER,
        PH_ISSUE,
        PH_WAIT,
        PH_PICK,
        PH_DONE
    } phase_e;

    localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

    function automatic logic [31:0] lfsr_next(input logic [31:0] cur);
        logic [31:0] nxt;
        nxt = cur >> 1;
        if (cur[0]) nxt = nxt ^ LFSR_TAPS;
        return nxt;
    endfunction

endpackage

// File: rtl/tg_addr_gen.sv
module tg_addr_gen #(
    parameter int AW       = 16,
    parameter int LEN_LOG2 = 4
) (
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] cur_i,
    input  logic [3:0]    aln_i,
    input  logic [AW-1:0] rnd_i,
    output logic [AW-1:0] seq_o,
    output logic [AW-1:0] rand_o
);
    logic [AW:0] sum;
    logic [AW:0] span;
    logic [AW:0] off;
    logic [AW:0] keep;
    logic [3:0]  shamt;

    always_comb begin
        sum   = {1'b0, cur_i} + {1'b0, step_i};
        seq_o = (sum > {1'b0, hi_i}) ? lo_i : sum[AW-1:0];

        span  = {1'b0, hi_i} - {1'b0, lo_i} + {{AW{1'b0}}, 1'b1};
        off   = (span == '0) ? '0 : ({1'b0, rnd_i} % span);
        shamt = (aln_i == 4'd0) ? 4'(LEN_LOG2) : aln_i;
        keep  = {(AW+1){1'b1}} << shamt;
        off   = off & keep;
        rand_o = lo_i + off[AW-1:0];
    end
endmodule

// File: rtl/tg_out_track.sv
module tg_out_track #(
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_i,
    input  logic          acc_wr_i,
    input  logic          rsp_i,
    input  logic          rsp_wr_i,
    input  logic [OW-1:0] lim_rd_i,
    input  logic [OW-1:0] lim_wr_i,
    output logic [OW-1:0] rd_cnt_o,
    output logic [OW-1:0] wr_cnt_o,
    output logic          stall_o
);
    logic [OW-1:0] cnt_q [2];
    logic [OW-1:0] cnt_d [2];

    for (genvar k = 0; k < 2; k++) begin : g_cnt
        logic inc;
        logic dec;
        always_comb begin
            inc      = acc_i && (acc_wr_i == 1'(k));
            dec      = rsp_i && (rsp_wr_i == 1'(k));
            cnt_d[k] = cnt_q[k];
            if (inc && !dec && cnt_q[k] != '1)
                cnt_d[k] = cnt_q[k] + 1'b1;
            else if (dec && !inc && cnt_q[k] != '0)
                cnt_d[k] = cnt_q[k] - 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[k] <= '0;
            else        cnt_q[k] <= cnt_d[k];
        end
    end

    assign rd_cnt_o = cnt_q[0];
    assign wr_cnt_o = cnt_q[1];
    assign stall_o  = (lim_rd_i != '0 && cnt_q[0] >= lim_rd_i) ||
                      (lim_wr_i != '0 && cnt_q[1] >= lim_wr_i);
endmodule

// File: rtl/tg_next_pick.sv
module tg_next_pick #(
    parameter int NS = 4,
    parameter int TW = 16,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [NS-1:0]    en_i,
    input  logic [NS*TW-1:0] thr_i,
    input  logic [TW-1:0]    draw_i,
    output logic             any_o,
    output logic [SW-1:0]    nxt_o
);
    logic          hit;
    logic [SW-1:0] hit_idx;
    logic [SW-1:0] last_idx;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        last_idx = '0;
        any_o    = 1'b0;
        for (int j = 0; j < NS; j++) begin
            if (en_i[j]) begin
                any_o    = 1'b1;
                last_idx = SW'(j);
                if (!hit && draw_i < thr_i[j*TW +: TW]) begin
                    hit     = 1'b1;
                    hit_idx = SW'(j);
                end
            end
        end
        nxt_o = hit ? hit_idx : last_idx;
    end
endmodule

// File: rtl/traffic_gen.sv
module traffic_gen
    import tg_pkg::*;
#(
    parameter int AW       = 16,
    parameter int NS       = 4,
    parameter int CW       = 16,
    parameter int OW       = 4,
    parameter int LEN_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      seed,
    input  logic [NS-1:0]    cfg_idle,
    input  logic [NS-1:0]    cfg_rand,
    input  logic [NS*CW-1:0] cfg_count,
    input  logic [NS*16-1:0] cfg_rdthr,
    input  logic [NS*AW-1:0] cfg_lo,
    input  logic [NS*AW-1:0] cfg_hi,
    input  logic [NS*AW-1:0] cfg_step,
    input  logic [NS*4-1:0]  cfg_aln,
    input  logic [NS*NS-1:0] cfg_trv,
    input  logic [NS*NS*16-1:0] cfg_trthr,
    input  logic [OW-1:0]    lim_rd,
    input  logic [OW-1:0]    lim_wr,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_write,
    output logic [AW-1:0]    req_addr,
    input  logic             rsp_valid,
    input  logic             rsp_write,
    output logic             done
);
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;
    localparam int TW = 16;

    typedef struct packed {
        phase_e        ph;
        logic [SW-1:0] cur;
        logic [CW-1:0] left;
        logic [AW-1:0] addr;
        logic          wr;
        logic [31:0]   lfsr;
    } gen_t;

    gen_t q, d;

    logic [31:0]    draw;
    logic           c_idle, c_rand;
    logic [CW-1:0]  c_cnt;
    logic [15:0]    c_thr;
    logic [AW-1:0]  cur_lo, cur_hi, c_step;
    logic [3:0]     c_aln;
    logic [NS-1:0]  c_trv;
    logic [NS*TW-1:0] c_trthr;
    logic [AW-1:0]  seq_addr, rnd_addr;
    logic           edge_any;
    logic [SW-1:0]  edge_nxt;
    logic           stall, accept, rd_hit;
    logic [OW-1:0]  rd_cnt, wr_cnt;

    always_comb begin : cfg_select
        c_idle  = cfg_idle[q.cur];
        c_rand  = cfg_rand[q.cur];
        c_cnt   = cfg_count[q.cur*CW +: CW];
        c_thr   = cfg_rdthr[q.cur*16 +: 16];
        cur_lo  = cfg_lo[q.cur*AW +: AW];
        cur_hi  = cfg_hi[q.cur*AW +: AW];
        c_step  = cfg_step[q.cur*AW +: AW];
        c_aln   = cfg_aln[q.cur*4 +: 4];
        c_trv   = cfg_trv[q.cur*NS +: NS];
        c_trthr = cfg_trthr[q.cur*NS*TW +: NS*TW];
    end

    assign draw   = lfsr_next(q.lfsr);
    assign rd_hit = draw[15:0] < c_thr;

    tg_addr_gen #(.AW(AW), .LEN_LOG2(LEN_LOG2)) u_addr (
        .lo_i   (cur_lo),
        .hi_i   (cur_hi),
        .step_i (c_step),
        .cur_i  (q.addr),
        .aln_i  (c_aln),
        .rnd_i  (draw[31 -: AW]),
        .seq_o  (seq_addr),
        .rand_o (rnd_addr)
    );

    tg_next_pick #(.NS(NS), .TW(TW)) u_pick (
        .en_i   (c_trv),
        .thr_i  (c_trthr),
        .draw_i (draw[15:0]),
        .any_o  (edge_any),
        .nxt_o  (edge_nxt)
    );

    tg_out_track #(.OW(OW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (accept),
        .acc_wr_i (q.wr),
        .rsp_i    (rsp_valid),
        .rsp_wr_i (rsp_write),
        .lim_rd_i (lim_rd),
        .lim_wr_i (lim_wr),
        .rd_cnt_o (rd_cnt),
        .wr_cnt_o (wr_cnt),
        .stall_o  (stall)
    );

    assign req_valid = (q.ph == PH_ISSUE) && !stall;
    assign accept    = req_valid && req_ready;
    assign req_write = q.wr;
    assign req_addr  = q.addr;
    assign done      = (q.ph == PH_DONE);

    always_comb begin : next_state
        d = q;
        unique case (q.ph)
            PH_OFF, PH_DONE: begin
                if (start) begin
                    d.lfsr = (seed == 32'd0) ? 32'd1 : seed;
                    d.cur  = '0;
                    d.ph   = PH_ENTER;
                end
            end
            PH_ENTER: begin
                d.lfsr = draw;
                d.left = c_cnt;
                if (c_cnt == '0) begin
                    d.ph = PH_PICK;
                end else if (c_idle) begin
                    d.ph = PH_WAIT;
                end else begin
                    d.ph   = PH_ISSUE;
                    d.wr   = !rd_hit;
                    d.addr = c_rand ? rnd_addr : cur_lo;
                end
            end
            PH_ISSUE: begin
                if (accept) begin
                    if (q.left == CW'(1)) begin
                        d.left = '0;
                        d.ph   = PH_PICK;
                    end else begin
                        d.left = q.left - 1'b1;
                        d.lfsr = draw;
                        d.wr   = !rd_hit;
                        d.addr = c_rand ? rnd_addr : seq_addr;
                    end
                end
            end
            PH_WAIT: begin
                d.left = q.left - 1'b1;
                if (q.left == CW'(1)) d.ph = PH_PICK;
            end
            PH_PICK: begin
                d.lfsr = draw;
                if (edge_any) begin
                    d.cur = edge_nxt;
                    d.ph  = PH_ENTER;
                end else begin
                    d.ph  = PH_DONE;
                end
            end
            default: d.ph = PH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_OFF;
            q.lfsr <= 32'd1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/tg_chk.sv
module tg_chk #(
    parameter int AW = 16,
    parameter int OW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic          rsp_write,
    input logic          done,
    input logic [OW-1:0] rd_cnt,
    input logic [OW-1:0] wr_cnt,
    input logic [OW-1:0] lim_rd,
    input logic [OW-1:0] lim_wr,
    input logic [AW-1:0] cur_lo,
    input logic [AW-1:0] cur_hi
);
    // R12
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write));

    // R9
    quiet_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    // R9
    end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    // R11
    rd_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_rd != '0 && rd_cnt >= lim_rd) |-> !req_valid);

    // R11
    wr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr != '0 && wr_cnt >= lim_wr) |-> !req_valid);

    // R10
    rd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && !(rsp_valid && !rsp_write) && rd_cnt != '1)
        |=> rd_cnt == $past(rd_cnt) + OW'(1));

    // R10
    wr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !(rsp_valid && rsp_write) && wr_cnt != '1)
        |=> wr_cnt == $past(wr_cnt) + OW'(1));

    // R10
    wr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && rsp_valid && rsp_write) |=> $stable(wr_cnt));

    // R4, R5
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr >= cur_lo && req_addr <= cur_hi));
endmodule

bind traffic_gen tg_chk #(.AW(AW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_write (rsp_write),
    .done      (done),
    .rd_cnt    (rd_cnt),
    .wr_cnt    (wr_cnt),
    .lim_rd    (lim_rd),
    .lim_wr    (lim_wr),
    .cur_lo    (cur_lo),
    .cur_hi    (cur_hi)
);

// File: tb/sim_traffic_gen.sv
module sim_traffic_gen;
    localparam int AW = 16;
    localparam int NS = 4;
    localparam int CW = 16;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             start = 1'b0;
    logic [31:0]      seed = 32'd0;
    logic [NS-1:0]    cfg_idle, cfg_rand;
    logic [NS*CW-1:0] cfg_count;
    logic [NS*16-1:0] cfg_rdthr;
    logic [NS*AW-1:0] cfg_lo, cfg_hi, cfg_step;
    logic [NS*4-1:0]  cfg_aln;
    logic [NS*NS-1:0] cfg_trv;
    logic [NS*NS*16-1:0] cfg_trthr;
    logic [OW-1:0]    lim_rd = '0, lim_wr = '0;
    logic req_valid, req_ready = 1'b0, req_write, rsp_valid = 1'b0, rsp_write = 1'b0, done;
    logic [AW-1:0] req_addr;

    bit          c_idle [NS], c_rand [NS];
    int unsigned c_cnt [NS], c_thr [NS], c_lo [NS], c_hi [NS], c_step [NS], c_aln [NS];
    bit          t_en [NS][NS];
    int unsigned t_thr [NS][NS];

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            cfg_idle[s] = c_idle[s];
            cfg_rand[s] = c_rand[s];
            cfg_count[s*CW +: CW] = CW'(c_cnt[s]);
            cfg_rdthr[s*16 +: 16] = 16'(c_thr[s]);
            cfg_lo[s*AW +: AW]    = AW'(c_lo[s]);
            cfg_hi[s*AW +: AW]    = AW'(c_hi[s]);
            cfg_step[s*AW +: AW]  = AW'(c_step[s]);
            cfg_aln[s*4 +: 4]     = 4'(c_aln[s]);
            for (int j = 0; j < NS; j++) begin
                cfg_trv[s*NS+j]            = t_en[s][j];
                cfg_trthr[(s*NS+j)*16 +: 16] = 16'(t_thr[s][j]);
            end
        end
    end

    traffic_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .cfg_idle(cfg_idle), .cfg_rand(cfg_rand), .cfg_count(cfg_count),
        .cfg_rdthr(cfg_rdthr), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_step(cfg_step),
        .cfg_aln(cfg_aln), .cfg_trv(cfg_trv), .cfg_trthr(cfg_trthr),
        .lim_rd(lim_rd), .lim_wr(lim_wr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_write(rsp_write), .done(done)
    );

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int unsigned m_lfsr, m_cur, m_left, m_addr, m_total, m_gap;
    bit          m_wr, m_done;

    function automatic int unsigned f_step(input int unsigned x);
        int unsigned n = x >> 1;
        if (x[0]) n = n ^ 32'h8020_0003;
        return n;
    endfunction

    function automatic int unsigned f_rand(input int unsigned lo, hi, aln, rnd);
        int unsigned span = hi - lo + 1;
        int unsigned off = (span == 0) ? 0 : rnd % span;
        int unsigned a = (aln == 0) ? 4 : aln;
        off = off & ~((32'd1 << a) - 1);
        return (lo + off) & 32'hFFFF;
    endfunction

    task automatic m_pick();
        int unsigned dr;
        int sel = -1, last = -1;
        m_lfsr = f_step(m_lfsr);
        dr = m_lfsr & 32'hFFFF;
        for (int j = 0; j < NS; j++) if (t_en[m_cur][j]) begin
            last = j;
            if (sel < 0 && dr < t_thr[m_cur][j]) sel = j;
        end
        if (last < 0) m_done = 1;
        else m_cur = (sel >= 0) ? sel : last;
    endtask

    task automatic m_enter();
        while (!m_done) begin
            m_lfsr = f_step(m_lfsr);
            if (c_cnt[m_cur] == 0 || c_idle[m_cur]) begin
                m_gap += 2 + (c_idle[m_cur] ? c_cnt[m_cur] : 0);
                m_pick();
            end else begin
                m_left  = c_cnt[m_cur];
                m_total += m_left;
                m_wr    = !((m_lfsr & 32'hFFFF) < c_thr[m_cur]);
                m_addr  = c_rand[m_cur] ? f_rand(c_lo[m_cur], c_hi[m_cur], c_aln[m_cur], m_lfsr >> 16)
                                        : c_lo[m_cur];
                return;
            end
        end
    endtask

    task automatic m_advance();
        if (m_left == 1) begin
            m_left = 0;
            m_gap  = 3;
            m_pick();
            m_enter();
        end else begin
            m_left--;
            m_gap  = 1;
            m_lfsr = f_step(m_lfsr);
            m_wr   = !((m_lfsr & 32'hFFFF) < c_thr[m_cur]);
            if (c_rand[m_cur])
                m_addr = f_rand(c_lo[m_cur], c_hi[m_cur], c_aln[m_cur], m_lfsr >> 16);
            else if (m_addr + c_step[m_cur] > c_hi[m_cur])
                m_addr = c_lo[m_cur];
            else
                m_addr = m_addr + c_step[m_cur];
        end
    endtask

    // ---------------- per-cycle driver ----------------
    int  n_cyc = 0, last_cyc = 0, acc_n = 0, pr = 0, pw = 0, rsp_pct = 100, rec_n = 0;
    bit  rnd_ready = 0, rsp_en = 1, gap_en = 0, have_last = 0, hold_p = 0, s_valid = 0;
    logic [AW-1:0] hold_a;
    logic          hold_w;
    int unsigned rec [256];

    task automatic tick();
        bit acc;
        @(negedge clk);
        n_cyc++;
        s_valid = req_valid;
        if ((lim_rd != 0 && pr >= lim_rd) || (lim_wr != 0 && pw >= lim_wr))
            chk(req_valid == 1'b0, "R11 offered at cap", req_valid, 0);
        if (hold_p && req_valid)
            chk(req_addr == hold_a && req_write == hold_w, "R12 held request changed", req_addr, hold_a);
        req_ready = rnd_ready ? ($urandom_range(0, 99) < 60) : 1'b1;
        rsp_valid = 1'b0;
        if (rsp_en && (pr + pw) > 0 && $urandom_range(0, 99) < rsp_pct) begin
            rsp_valid = 1'b1;
            if (pr > 0 && (pw == 0 || $urandom_range(0, 1) == 0)) begin
                rsp_write = 1'b0; pr--;
            end else begin
                rsp_write = 1'b1; pw--;
            end
        end
        acc = req_valid && req_ready;
        if (acc) begin
            if (m_done) chk(1'b0, "R9 request after end", req_addr, 0);
            else begin
                chk(req_write == m_wr, "R3 access type", req_write, m_wr);
                chk(req_addr == AW'(m_addr), "R4 R5 R8 address", req_addr, m_addr);
                if (gap_en && have_last)
                    chk(n_cyc - last_cyc == int'(m_gap), "R7 spacing", n_cyc - last_cyc, m_gap);
                m_advance();
            end
            last_cyc = n_cyc; have_last = 1;
            if (rec_n < 256) rec[rec_n] = req_addr;
            rec_n++; acc_n++;
            if (req_write) pw++; else pr++;
        end
        hold_p = req_valid && !req_ready;
        hold_a = req_addr;
        hold_w = req_write;
    endtask

    task automatic begin_run(input int unsigned sd);
        seed = sd;
        @(negedge clk);
        start = 1'b1;
        m_lfsr = (sd == 0) ? 1 : sd; m_cur = 0; m_done = 0; m_total = 0; m_gap = 0;
        m_enter();
        acc_n = 0; rec_n = 0; have_last = 0; hold_p = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_to_done(input int maxc);
        int k = 0;
        while (!(m_done && done)) begin
            tick();
            k++;
            if (k > maxc) begin
                chk(1'b0, "R9 run did not end", done, 1);
                break;
            end
        end
        chk(done == 1'b1 && req_valid == 1'b0, "R9 end state", {done, req_valid}, 2'b10);
        chk(acc_n == int'(m_total), "R6 request total", acc_n, m_total);
        rsp_en = 1; rsp_pct = 100;
        while (pr + pw > 0) tick();
    endtask

    task automatic clear_cfg();
        for (int s = 0; s < NS; s++) begin
            c_idle[s] = 0; c_rand[s] = 0; c_cnt[s] = 0; c_thr[s] = 0;
            c_lo[s] = 0; c_hi[s] = 16'hFFFF; c_step[s] = 1; c_aln[s] = 0;
            for (int j = 0; j < NS; j++) begin t_en[s][j] = 0; t_thr[s][j] = 0; end
        end
    endtask

    int unsigned keep [16];
    int          keep_n;
    bit          fired = 0;

    initial begin
        void'($urandom(32'd4242));
        clear_cfg();
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0 && done == 1'b0, "R1 reset outputs", {req_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0 && done == 1'b0, "R1 idle after reset", {req_valid, done}, 0);

        // directed: wrapping stepping phase, wait phase, random phase
        c_cnt[0] = 5; c_lo[0] = 16'h100; c_hi[0] = 16'h300; c_step[0] = 16'h100; c_thr[0] = 16'hFFFF;
        t_en[0][1] = 1; t_thr[0][1] = 16'hFFFF;
        c_idle[1] = 1; c_cnt[1] = 7; t_en[1][2] = 1; t_thr[1][2] = 16'hFFFF;
        c_rand[2] = 1; c_cnt[2] = 6; c_lo[2] = 16'h4000; c_hi[2] = 16'h7FFF; c_thr[2] = 16'h8000;
        gap_en = 1; rnd_ready = 0; rsp_pct = 100;
        begin_run(32'h1234_5678);
        run_to_done(500);
        chk(rec[0] == 16'h100 && rec[1] == 16'h200 && rec[2] == 16'h300, "R4 step order", rec[2], 16'h300);
        chk(rec[3] == 16'h100 && rec[4] == 16'h200, "R4 wrap to lower bound", rec[3], 16'h100);
        for (int i = 5; i < 11; i++)
            chk(rec[i] >= 16'h4000 && rec[i] <= 16'h7FFF && rec[i][3:0] == 4'h0,
                "R5 random window and alignment", rec[i], 16'h4000);
        keep_n = rec_n;
        for (int i = 0; i < 16; i++) keep[i] = rec[i];

        begin_run(32'h1234_5678);
        run_to_done(500);
        chk(rec_n == keep_n, "R2 repeat length", rec_n, keep_n);
        for (int i = 0; i < 11; i++) chk(rec[i] == keep[i], "R2 repeat stream", rec[i], keep[i]);

        // directed branch: first edge never qualifies, second always does
        clear_cfg();
        c_cnt[0] = 1; c_lo[0] = 16'h10;
        t_en[0][1] = 1; t_thr[0][1] = 0; t_en[0][2] = 1; t_thr[0][2] = 16'hFFFF;
        c_cnt[1] = 1; c_lo[1] = 16'h1000;
        c_cnt[2] = 1; c_lo[2] = 16'h2000;
        begin_run(32'h0);
        run_to_done(200);
        chk(rec_n == 2 && rec[1] == 16'h2000, "R8 branch taken", rec[1], 16'h2000);
        gap_en = 0;

        // directed cap: write-only phase, responses withheld
        clear_cfg();
        c_cnt[0] = 6; c_step[0] = 16'h10; c_thr[0] = 0;
        lim_wr = 2;
        begin_run(32'hBEEF);
        rsp_en = 0;
        repeat (10) tick();
        chk(acc_n == 2, "R11 held at write cap", acc_n, 2);
        chk(s_valid == 1'b0, "R11 no offer at cap", s_valid, 0);
        rsp_en = 1; rsp_pct = 100;
        tick();
        rsp_en = 0;
        tick();
        chk(s_valid == 1'b1, "R10 one response frees a slot", s_valid, 1);
        rsp_en = 1;
        run_to_done(500);

        // random tables, forward-only edges
        rnd_ready = 1;
        for (int it = 0; it < 30; it++) begin
            clear_cfg();
            for (int s = 0; s < NS; s++) begin
                int unsigned acc_t = 0;
                c_idle[s] = ($urandom_range(0, 3) == 0);
                c_rand[s] = $urandom_range(0, 1);
                c_cnt[s]  = c_idle[s] ? $urandom_range(0, 20) : $urandom_range(0, 12);
                c_thr[s]  = $urandom_range(0, 16'hFFFF);
                c_lo[s]   = $urandom_range(0, 16'h7FF0);
                c_hi[s]   = c_lo[s] + $urandom_range(16'h40, 16'h4000);
                c_step[s] = $urandom_range(1, 16'h800);
                c_aln[s]  = $urandom_range(0, 6);
                for (int j = s + 1; j < NS; j++) begin
                    t_en[s][j] = $urandom_range(0, 1);
                    acc_t = acc_t + $urandom_range(0, 16'h5000);
                    t_thr[s][j] = (acc_t > 16'hFFFF) ? 16'hFFFF : acc_t;
                end
            end
            lim_rd = OW'($urandom_range(0, 3));
            lim_wr = OW'($urandom_range(0, 3));
            rsp_pct = $urandom_range(20, 90);
            begin_run($urandom);
            run_to_done(5000);
        end
        fired = 1;
    end

    initial begin
        int wd = 0;
        while (!fired && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!fired) chk(1'b0, "R9 watchdog expired", wd, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule